// File: doc/BRIEF.md
# NAND Block-Erase Command Sequencer

This block runs one block-erase operation on an 8-bit asynchronous NAND flash device on behalf of a host. The host offers a row address on a valid/ready request port. The block latches the address and the strobe timing. It then drives chip enable, the command and address latch enables and the write-enable strobe to send an erase-setup command, the row address and an erase-confirm command. After that it waits for the device's ready/busy line, sends a status-read command and reads one status byte with the read-enable strobe. It reports the outcome as a one-cycle done pulse with pass/fail and timeout flags.

The low page bits of the row are forced to zero, because the device erases a whole block. The width of the low and high phases of each strobe comes from configuration inputs. Parameters set a floor under both widths. The ready/busy line is synchronised, and it is ignored for a fixed number of cycles after the confirm strobe. This covers the delay before the device pulls it low. A counter limits how long the block waits for the device. The data lane is split into an output byte, an output enable and an input byte, so a pad can be built outside the block.

Top module: `nand_erase_seq`

## Requirements
- R1: The first bus cycle of an operation is a write strobe carrying 0x60 with `nf_cle`=1 and `nf_ale`=0. `nf_cle` and `nf_ale` are never high together, and no strobe occurs while `nf_ce_n` is high.
- R2: Exactly two address write strobes (`nf_ale`=1, `nf_cle`=0) follow the setup command. The first carries `req_row[7:0]` and the second carries `req_row[15:8]`.
- R3: The lowest PAGE_BITS bits of the row (6 by default) are driven as zero in the address cycles, whatever the request holds.
- R4: The address cycles are followed by a write strobe carrying 0xD0 with `nf_cle`=1.
- R5: After the confirm strobe, the block issues no strobe while the device reports busy. Ready/busy is not monitored for WB_DELAY cycles after the confirm strobe completes.
- R6: Once ready is seen, the block sends 0x70 with `nf_cle`=1, then one read strobe, and samples the status byte. The result is fail when bit 0 is 1 or bit 6 is 0. Otherwise it is pass.
- R7: Every write or read strobe is low for max(`cfg_we_low`, MIN_WE_LOW) cycles and then high for at least max(`cfg_we_high`, MIN_WE_HIGH) cycles. The widths are latched when the request is accepted.
- R8: If the synchronised ready/busy stays low for MAX_BUSY_CYC monitored cycles, the block ends with `done`=1, `done_timeout`=1 and `done_fail`=1, and reads no status. Ready seen in the last monitored cycle wins over the timeout.
- R9: `req_ready` is low from the cycle after acceptance until the cycle of `done`. `done` is high for exactly one cycle per operation.
- R10: `nf_io_oe` is high only during command and address cycles. It is low while the read strobe is low.
- R11: After reset, `nf_ce_n`, `nf_we_n` and `nf_re_n` are high, `nf_cle`, `nf_ale`, `nf_io_oe` and `done` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Erase request offered |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_row | input | ROW_W | Row address of the block to erase |
| cfg_we_low | input | TW | Requested strobe low width in cycles |
| cfg_we_high | input | TW | Requested strobe high width in cycles |
| done | output | 1 | One-cycle completion pulse |
| done_fail | output | 1 | Erase failed or timed out (valid with done) |
| done_timeout | output | 1 | Busy wait expired (valid with done) |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | Byte driven onto the I/O lane |
| nf_io_oe | output | 1 | Output enable for the I/O lane |
| nf_io_in | input | 8 | Byte read from the I/O lane |
| nf_rb_n | input | 1 | Device ready (1) / busy (0) |

## Verification
The device returning ready and the busy-wait counter reaching its limit can occur in the same cycle. The bench's flash responder holds ready/busy low for a chosen number of cycles after the confirm strobe's rising edge. From the strobe width, the ignore window and the two synchroniser stages, the bench computes the longest busy time that still makes ready arrive in the last monitored cycle. One erase uses exactly that length and must end in a status read and a pass. A second uses one cycle more and must end in a timeout with no status command on the bus.

// File: rtl/nand_erase_pkg.sv
// Shared types and command bytes for the NAND block-erase sequencer.
// Assumes an 8-bit NAND lane and a status byte with fail at bit 0 and ready at bit 6.
package nand_erase_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_SETUP,
        SEQ_ADDR,
        SEQ_CONFIRM,
        SEQ_WAIT,
        SEQ_STAT_CMD,
        SEQ_STAT_RD
    } seq_state_t;

    localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
    localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
    localparam logic [7:0] OP_STATUS      = 8'h70;

    localparam int STAT_FAIL_BIT = 0;
    localparam int STAT_RDY_BIT  = 6;

endpackage

// File: rtl/nand_rb_sync.sv
// Synchroniser for the asynchronous ready/busy pin.
// Assumes STAGES >= 2. The chain resets to 1 (ready), so no false busy follows reset.
module nand_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    // Shift the pin value through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/nand_strobe_gen.sv
// Generates one active-low strobe: low for low_cyc cycles, then high for high_cyc cycles.
// A strobe starts from idle whenever go is high. done marks the last high cycle.
// Assumes low_cyc and high_cyc are at least 1 and stay stable during a strobe.
module nand_strobe_gen #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [TW-1:0] low_cyc,
    input  logic [TW-1:0] high_cyc,
    output logic          strobe_n,
    output logic          done
);

    typedef enum logic [1:0] {SG_IDLE, SG_LOW, SG_HIGH} sg_state_t;

    sg_state_t     st_q;
    logic [TW-1:0] cnt_q;

    // Step through the idle, low and high phases and count the cycles of each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SG_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                SG_IDLE: begin
                    cnt_q <= '0;
                    if (go) st_q <= SG_LOW;
                end
                SG_LOW: begin
                    if (cnt_q == low_cyc - TW'(1)) begin
                        st_q  <= SG_HIGH;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + TW'(1);
                    end
                end
                SG_HIGH: begin
                    if (cnt_q == high_cyc - TW'(1)) begin
                        st_q  <= SG_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + TW'(1);
                    end
                end
                default: begin
                    st_q  <= SG_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign strobe_n = (st_q != SG_LOW);
    assign done     = (st_q == SG_HIGH) && (cnt_q == high_cyc - TW'(1));

endmodule

// File: rtl/nand_busy_wait.sv
// Waits for the device after the erase confirm strobe.
// First it ignores ready/busy for WB_DELAY cycles. Then it watches the synchronised line
// for up to MAX_BUSY_CYC cycles. Ready takes priority over timeout in the same cycle.
// Assumes go stays high until ready or timeout is seen. A low go rearms the block.
module nand_busy_wait #(
    parameter int WB_DELAY     = 4,
    parameter int MAX_BUSY_CYC = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic rb_ready,
    output logic ready,
    output logic timeout
);

    localparam int SPAN = (MAX_BUSY_CYC > WB_DELAY) ? MAX_BUSY_CYC : WB_DELAY;
    localparam int CW   = $clog2(SPAN + 1);
    localparam logic [CW-1:0] WB_LAST  = CW'(WB_DELAY - 1);
    localparam logic [CW-1:0] MAX_LAST = CW'(MAX_BUSY_CYC - 1);

    logic          mon_q;
    logic [CW-1:0] cnt_q;

    // Count the ignore window, then count the monitored busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !go) begin
            mon_q <= 1'b0;
            cnt_q <= '0;
        end else if (!mon_q) begin
            if (cnt_q == WB_LAST) begin
                mon_q <= 1'b1;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end else if (!rb_ready && cnt_q != MAX_LAST) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign ready   = go && mon_q && rb_ready;
    assign timeout = go && mon_q && !rb_ready && (cnt_q == MAX_LAST);

endmodule

// File: rtl/nand_erase_seq.sv
// Top of the NAND block-erase sequencer.
// It accepts one request, sends the setup command, the row address cycles and the confirm
// command, waits for ready, reads the status byte and pulses done with the result.
// Assumes a pad outside splits the lane into nf_io_out/nf_io_oe/nf_io_in.
// Assumes WB_DELAY plus the strobe high width is at least SYNC_STAGES.
module nand_erase_seq
    import nand_erase_pkg::*;
#(
    parameter int ROW_W        = 16,
    parameter int PAGE_BITS    = 6,
    parameter int TW           = 4,
    parameter int MIN_WE_LOW   = 2,
    parameter int MIN_WE_HIGH  = 2,
    parameter int WB_DELAY     = 4,
    parameter int MAX_BUSY_CYC = 2000000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [TW-1:0]    cfg_we_low,
    input  logic [TW-1:0]    cfg_we_high,
    output logic             done,
    output logic             done_fail,
    output logic             done_timeout,
    output logic             nf_ce_n,
    output logic             nf_cle,
    output logic             nf_ale,
    output logic             nf_we_n,
    output logic             nf_re_n,
    output logic [7:0]       nf_io_out,
    output logic             nf_io_oe,
    input  logic [7:0]       nf_io_in,
    input  logic             nf_rb_n
);

    localparam int ADDR_CYC = (ROW_W + 7) / 8;
    localparam int ROW_PAD  = ADDR_CYC * 8;
    localparam int ACW      = (ADDR_CYC > 1) ? $clog2(ADDR_CYC) : 1;
    localparam logic [ACW-1:0]     ADDR_LAST = ACW'(ADDR_CYC - 1);
    localparam logic [TW-1:0]      LOW_FLOOR  = TW'(MIN_WE_LOW);
    localparam logic [TW-1:0]      HIGH_FLOOR = TW'(MIN_WE_HIGH);
    localparam logic [ROW_W-1:0]   PAGE_MASK  = ~((ROW_W)'((1 << PAGE_BITS) - 1));

    seq_state_t           st_q;
    logic [ACW-1:0]       acnt_q;
    logic [ROW_PAD-1:0]   row_q;
    logic [TW-1:0]        low_q;
    logic [TW-1:0]        high_q;
    logic                 rd_fail_q;
    logic                 rd_rdy_q;
    logic                 done_q;
    logic                 fail_q;
    logic                 tmo_q;

    logic                 we_go;
    logic                 we_done;
    logic                 re_go;
    logic                 re_done;
    logic                 rb_sync;
    logic                 bw_ready;
    logic                 bw_timeout;

    // Synchronise the ready/busy pin.
    nand_rb_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (nf_rb_n),
        .sync_out (rb_sync)
    );

    // Write strobe generator for the command and address cycles.
    nand_strobe_gen #(.TW(TW)) u_we_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (we_go),
        .low_cyc  (low_q),
        .high_cyc (high_q),
        .strobe_n (nf_we_n),
        .done     (we_done)
    );

    // Read strobe generator for the status byte.
    nand_strobe_gen #(.TW(TW)) u_re_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (re_go),
        .low_cyc  (low_q),
        .high_cyc (high_q),
        .strobe_n (nf_re_n),
        .done     (re_done)
    );

    // Ignore window and bounded wait for the device.
    nand_busy_wait #(.WB_DELAY(WB_DELAY), .MAX_BUSY_CYC(MAX_BUSY_CYC)) u_busy_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (st_q == SEQ_WAIT),
        .rb_ready (rb_sync),
        .ready    (bw_ready),
        .timeout  (bw_timeout)
    );

    assign we_go = (st_q == SEQ_SETUP) || (st_q == SEQ_ADDR) ||
                   (st_q == SEQ_CONFIRM) || (st_q == SEQ_STAT_CMD);
    assign re_go = (st_q == SEQ_STAT_RD);

    // Main sequence: advance on each strobe completion and on the busy-wait outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SEQ_IDLE;
            acnt_q <= '0;
            row_q  <= '0;
            low_q  <= LOW_FLOOR;
            high_q <= HIGH_FLOOR;
            done_q <= 1'b0;
            fail_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            tmo_q  <= 1'b0;
            case (st_q)
                SEQ_IDLE: begin
                    if (req_valid) begin
                        row_q  <= ROW_PAD'(req_row & PAGE_MASK);
                        low_q  <= (cfg_we_low < LOW_FLOOR) ? LOW_FLOOR : cfg_we_low;
                        high_q <= (cfg_we_high < HIGH_FLOOR) ? HIGH_FLOOR : cfg_we_high;
                        acnt_q <= '0;
                        st_q   <= SEQ_SETUP;
                    end
                end
                SEQ_SETUP: begin
                    if (we_done) st_q <= SEQ_ADDR;
                end
                SEQ_ADDR: begin
                    if (we_done) begin
                        row_q <= row_q >> 8;
                        if (acnt_q == ADDR_LAST) begin
                            st_q <= SEQ_CONFIRM;
                        end else begin
                            acnt_q <= acnt_q + ACW'(1);
                        end
                    end
                end
                SEQ_CONFIRM: begin
                    if (we_done) st_q <= SEQ_WAIT;
                end
                SEQ_WAIT: begin
                    if (bw_ready) begin
                        st_q <= SEQ_STAT_CMD;
                    end else if (bw_timeout) begin
                        st_q   <= SEQ_IDLE;
                        done_q <= 1'b1;
                        fail_q <= 1'b1;
                        tmo_q  <= 1'b1;
                    end
                end
                SEQ_STAT_CMD: begin
                    if (we_done) st_q <= SEQ_STAT_RD;
                end
                SEQ_STAT_RD: begin
                    if (re_done) begin
                        st_q   <= SEQ_IDLE;
                        done_q <= 1'b1;
                        fail_q <= rd_fail_q || !rd_rdy_q;
                    end
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

    // Sample the two status flags on every cycle the read strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_fail_q <= 1'b0;
            rd_rdy_q  <= 1'b0;
        end else if (!nf_re_n) begin
            rd_fail_q <= nf_io_in[STAT_FAIL_BIT];
            rd_rdy_q  <= nf_io_in[STAT_RDY_BIT];
        end
    end

    // Decode the pin levels from the sequence state.
    always_comb begin
        nf_cle    = 1'b0;
        nf_ale    = 1'b0;
        nf_io_out = 8'h00;
        case (st_q)
            SEQ_SETUP:    begin nf_cle = 1'b1; nf_io_out = OP_ERASE_SETUP; end
            SEQ_ADDR:     begin nf_ale = 1'b1; nf_io_out = row_q[7:0];     end
            SEQ_CONFIRM:  begin nf_cle = 1'b1; nf_io_out = OP_ERASE_GO;    end
            SEQ_STAT_CMD: begin nf_cle = 1'b1; nf_io_out = OP_STATUS;      end
            default:      ;
        endcase
    end

    assign nf_io_oe     = nf_cle || nf_ale;
    assign nf_ce_n      = (st_q == SEQ_IDLE);
    assign req_ready    = (st_q == SEQ_IDLE);
    assign done         = done_q;
    assign done_fail    = fail_q;
    assign done_timeout = tmo_q;

endmodule

// File: rtl/nand_erase_chk.sv
// Assertion checker for nand_erase_seq, attached by bind. It watches the pins only.
// Assumes MIN_WE_LOW matches the bound instance.
module nand_erase_chk #(
    parameter int MIN_WE_LOW = 2
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic done_fail,
    input logic done_timeout,
    input logic nf_ce_n,
    input logic nf_cle,
    input logic nf_ale,
    input logic nf_we_n,
    input logic nf_re_n,
    input logic nf_io_oe
);

    AST_CMD_ADDR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale)); // R1

    AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n || !nf_re_n) |-> !nf_ce_n); // R1

    AST_OE_OFF_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_re_n |-> !nf_io_oe); // R10

    AST_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_we_n |-> nf_io_oe); // R10

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R9

    AST_TIMEOUT_IS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        done_timeout |-> (done && done_fail)); // R8

    generate
        if (MIN_WE_LOW >= 2) begin : g_low_min
            AST_WE_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(nf_we_n) |=> !nf_we_n); // R7
        end
    endgenerate

endmodule

bind nand_erase_seq nand_erase_chk #(.MIN_WE_LOW(MIN_WE_LOW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .done         (done),
    .done_fail    (done_fail),
    .done_timeout (done_timeout),
    .nf_ce_n      (nf_ce_n),
    .nf_cle       (nf_cle),
    .nf_ale       (nf_ale),
    .nf_we_n      (nf_we_n),
    .nf_re_n      (nf_re_n),
    .nf_io_oe     (nf_io_oe)
);

// File: tb/test_nand_erase_seq.sv
// Scoreboard bench. The driver task queues the expected bus cycles and results.
// The negedge monitor models the flash, pops the queues and compares.
module test_nand_erase_seq;

    localparam int CLK_PERIOD = 10;
    localparam int ROW_W      = 16;
    localparam int PAGE_BITS  = 6;
    localparam int TW         = 4;
    localparam int MIN_LOW    = 2;
    localparam int MIN_HIGH   = 2;
    localparam int WB         = 4;
    localparam int MAX_BUSY   = 40;
    localparam int SYNC       = 2;

    typedef struct packed { logic cle; logic ale; logic [7:0] b; } bus_item_t;
    typedef struct packed { logic fail; logic tmo; } res_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [ROW_W-1:0] req_row = '0;
    logic [TW-1:0]    cfg_we_low = '0;
    logic [TW-1:0]    cfg_we_high = '0;
    logic             done, done_fail, done_timeout;
    logic             nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
    logic [7:0]       nf_io_out;
    logic [7:0]       nf_io_in;
    logic             rb_n = 1'b1;

    bus_item_t exp_bus[$];
    res_t      exp_res[$];
    int        checks = 0;
    int        failures = 0;
    int        exp_low = MIN_LOW;
    int        exp_high = MIN_HIGH;
    int        busy_len = 1;
    int        busy_left = 0;
    logic [7:0] status_byte = 8'h40;
    bit        op_active = 1'b0;
    bit        finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign nf_io_in = status_byte;

    nand_erase_seq #(
        .ROW_W(ROW_W), .PAGE_BITS(PAGE_BITS), .TW(TW),
        .MIN_WE_LOW(MIN_LOW), .MIN_WE_HIGH(MIN_HIGH),
        .WB_DELAY(WB), .MAX_BUSY_CYC(MAX_BUSY), .SYNC_STAGES(SYNC)
    ) i_nand_erase_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .cfg_we_low(cfg_we_low), .cfg_we_high(cfg_we_high),
        .done(done), .done_fail(done_fail), .done_timeout(done_timeout),
        .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
        .nf_re_n(nf_re_n), .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe),
        .nf_io_in(nf_io_in), .nf_rb_n(rb_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Flash responder and monitor, all evaluated at the falling edge.
    logic prev_we = 1'b1, prev_re = 1'b1, prev_done = 1'b0;
    int   we_low_cnt = 0, re_low_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            // Busy countdown of the model.
            if (busy_left > 0) begin
                busy_left--;
                if (busy_left == 0) rb_n = 1'b1;
            end
            // Result scoreboard first, so the ready check sees the op closed.
            if (done) begin
                res_t r;
                chk(prev_done == 1'b0, "R9", "done longer than one cycle", 1, 0);
                if (exp_res.size() == 0) begin
                    chk(1'b0, "R9", "unexpected done", 1, 0);
                end else begin
                    r = exp_res.pop_front();
                    chk(done_fail == r.fail, "R6/R8", "done_fail", done_fail, r.fail);
                    chk(done_timeout == r.tmo, "R8", "done_timeout", done_timeout, r.tmo);
                end
                op_active = 1'b0;
            end
            if (op_active && req_ready)
                chk(1'b0, "R9", "req_ready high during operation", 1, 0);
            // Write strobe: count the low width, compare the latched item at the rising edge.
            if (!nf_we_n) we_low_cnt++;
            if (!prev_we && nf_we_n) begin
                bus_item_t it;
                chk(we_low_cnt == exp_low, "R7", "write strobe low width", we_low_cnt, exp_low);
                chk(rb_n == 1'b1, "R5", "strobe while device busy", 0, 1);
                chk(nf_io_oe == 1'b1, "R10", "lane not driven on write", nf_io_oe, 1);
                if (exp_bus.size() == 0) begin
                    chk(1'b0, "R5", "unexpected write strobe", nf_io_out, 0);
                end else begin
                    it = exp_bus.pop_front();
                    chk(nf_cle == it.cle, "R1/R2/R4/R6", "cle", nf_cle, it.cle);
                    chk(nf_ale == it.ale, "R1/R2", "ale", nf_ale, it.ale);
                    chk(nf_io_out == it.b, "R1/R2/R3/R4/R6", "byte", nf_io_out, it.b);
                    if (it.cle && it.b == 8'hD0) begin
                        rb_n = 1'b0;
                        busy_left = busy_len;
                    end
                end
                we_low_cnt = 0;
            end
            // Read strobe: the lane must be released, and the width matches.
            if (!nf_re_n) begin
                re_low_cnt++;
                chk(nf_io_oe == 1'b0, "R10", "lane driven during read", nf_io_oe, 0);
            end
            if (!prev_re && nf_re_n) begin
                chk(re_low_cnt == exp_low, "R7", "read strobe low width", re_low_cnt, exp_low);
                re_low_cnt = 0;
            end
            prev_we   = nf_we_n;
            prev_re   = nf_re_n;
            prev_done = done;
        end
    end

    // Driver: push the expected items, then issue one request and wait for its result.
    task automatic run_erase(input logic [15:0] row, input int lo, input int hi,
                             input logic [7:0] stat, input int blen);
        int    limit;
        res_t  r;
        logic [15:0] mrow;
        while (!rb_n) @(negedge clk);
        exp_low  = (lo < MIN_LOW) ? MIN_LOW : lo;
        exp_high = (hi < MIN_HIGH) ? MIN_HIGH : hi;
        limit    = MAX_BUSY + exp_high + WB - 1 - SYNC;
        mrow     = row & ~16'((1 << PAGE_BITS) - 1);
        busy_len    = blen;
        status_byte = stat;
        exp_bus.push_back('{cle: 1'b1, ale: 1'b0, b: 8'h60});
        exp_bus.push_back('{cle: 1'b0, ale: 1'b1, b: mrow[7:0]});
        exp_bus.push_back('{cle: 1'b0, ale: 1'b1, b: mrow[15:8]});
        exp_bus.push_back('{cle: 1'b1, ale: 1'b0, b: 8'hD0});
        if (blen > limit) begin
            r.fail = 1'b1; r.tmo = 1'b1;
        end else begin
            exp_bus.push_back('{cle: 1'b1, ale: 1'b0, b: 8'h70});
            r.fail = stat[0] | ~stat[6]; r.tmo = 1'b0;
        end
        exp_res.push_back(r);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_row     = row;
        cfg_we_low  = TW'(lo);
        cfg_we_high = TW'(hi);
        req_valid   = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        op_active = 1'b1;
        while (exp_res.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_bus.size() == 0, "R2/R6", "missing bus cycles", exp_bus.size(), 0);
        exp_bus.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(nf_ce_n == 1'b1, "R11", "ce_n", nf_ce_n, 1);
        chk(nf_we_n == 1'b1 && nf_re_n == 1'b1, "R11", "strobes", {nf_we_n, nf_re_n}, 3);
        chk(!nf_cle && !nf_ale && !nf_io_oe, "R11", "cle/ale/oe", {nf_cle, nf_ale, nf_io_oe}, 0);
        chk(req_ready == 1'b1 && done == 1'b0, "R11", "ready/done", {req_ready, done}, 2);
        // Passing erase, page bits set in the request (R1..R4, R6).
        run_erase(16'hABCD, 3, 2, 8'h40, 10);
        // Fail bit set, widths below the floor (R6, R7).
        run_erase(16'h1234, 0, 0, 8'h41, 6);
        // Ready bit clear counts as fail (R6).
        run_erase(16'hFFFF, 2, 3, 8'h00, 5);
        // Very short busy, ignore window must mask it (R5).
        run_erase(16'h0080, 2, 2, 8'hE0, 1);
        // Ready in the last monitored cycle wins over timeout (R8).
        run_erase(16'h5A5A, 2, 2, 8'h40, MAX_BUSY + 2 + WB - 1 - SYNC);
        // One cycle longer: timeout, no status command (R8).
        run_erase(16'hA5C3, 2, 2, 8'h40, MAX_BUSY + 2 + WB - SYNC);
        // Wide strobes after a timeout (R7).
        run_erase(16'h0F3F, 7, 5, 8'h40, 12);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule